// File: doc/BRIEF.md
# Display PHY Power-Up Sequencer

This block brings up the analog support of a serial display link PHY in a fixed order. When it is enabled and receives a start strobe, it first checks the PLL divider settings it has been given. If they are legal, it turns on the bandgap reference and the regulator together. It waits for the regulator to report ready, then turns on the PLL and waits for lock. Each wait has its own time limit. If a limit runs out, the bring-up is abandoned, every enable is turned off, and the block reports which of the two waits failed.

The divider settings and the 6-bit unit-interval value (four times the bit period, in the units the PHY expects) are captured at start and held on the outputs for the PHY. The output divider is handed on as a 2-bit log2 code. The wrapper enable toward the pixel path follows the mode input: it can be on only in video mode, once the PLL is locked, and is held low in command mode. Dropping the enable input turns off the PLL first, turns off the regulator and bandgap one cycle later, and returns the block to idle.

Top module: `phy_pwr_seq`

## Requirements
- R1: A start strobe sampled while enable is high, the block is idle or failed, and the dividers are legal sets bgEn and regEn in the next cycle. pllEn stays low until the regulator reports ready.
- R2: pllEn rises in the cycle after regReady is sampled high during the regulator wait, and never earlier.
- R3: done is high for exactly one cycle, in the cycle after pllLock is sampled high during the PLL wait.
- R4: Each wait lasts at most LIMIT = CYCLES_PER_US*TIMEOUT_US cycles. A ready or lock seen in the last of those cycles is still accepted.
- R5: When a wait times out, timeoutErr goes high and all enables go low. failStep is 0 for a regulator timeout and 1 for a PLL timeout.
- R6: The legal divider values are idf 1..7, ndiv 10..125, and odf in {1,2,4,8}. A start with any value outside these ranges sets paramErr in the next cycle and turns on no enable.
- R7: On a legal start, idfOut and ndivOut take the input values. odfCode takes log2(odf): 1 gives 0, 2 gives 1, 4 gives 2, 8 gives 3.
- R8: uix4Out captures the 6-bit uix4In value at a legal start.
- R9: wrapEn is high only while the PLL is locked and running and videoMode is high. It is low in command mode.
- R10: When enable is sampled low while the block is active, pllEn drops in the next cycle with regEn and bgEn still high. Those two drop one cycle later, and the block is idle.
- R11: A start while enable is low, or while a sequence is in progress, has no effect. paramErr and timeoutErr are cleared by the next start that is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Keeps the PHY powered; low requests shutdown |
| start | input | 1 | One-cycle bring-up request |
| videoMode | input | 1 | 1 = video mode, 0 = command mode |
| idfIn | input | 4 | PLL input divider |
| ndivIn | input | 7 | PLL loop multiplier |
| odfIn | input | 4 | PLL output divider (1, 2, 4 or 8) |
| uix4In | input | 6 | Unit interval times four |
| regReady | input | 1 | Regulator ready status |
| pllLock | input | 1 | PLL lock status |
| bgEn | output | 1 | Bandgap reference enable |
| regEn | output | 1 | Regulator enable |
| pllEn | output | 1 | PLL enable |
| wrapEn | output | 1 | Wrapper enable, video mode only |
| idfOut | output | 4 | Captured input divider |
| ndivOut | output | 7 | Captured loop multiplier |
| odfCode | output | 2 | log2 of the captured output divider |
| uix4Out | output | 6 | Captured unit-interval field |
| done | output | 1 | One-cycle pulse when lock is reached |
| paramErr | output | 1 | Last start was rejected for an illegal divider |
| timeoutErr | output | 1 | A wait timed out |
| failStep | output | 1 | Step that timed out: 0 = regulator, 1 = PLL |

## Verification
A start strobe registered at one edge shows its effect on the enables, the captured fields and paramErr in the cycle right after that edge. A status input sampled at an edge moves the next enable or done one cycle later. A wait with no response flags timeoutErr exactly LIMIT edges after it was entered. The bench drives every input at a falling edge and samples one falling edge after the rising edge that should act on it. This is how it checks the last accepted ready cycle, the first timeout cycle and the one-cycle gap in the two-step shutdown. The divider sweep covers every idf and odf code against the ndiv boundary values.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WREG, ST_WPLL, ST_UP, ST_DOWN, ST_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic cntClr;
    logic cntEn;
  } dpCtl_t;
endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int IDF_W    = 4,
  parameter int NDIV_W   = 7,
  parameter int ODF_W    = 4,
  parameter int UI_W     = 6,
  parameter int IDF_MIN  = 1,
  parameter int IDF_MAX  = 7,
  parameter int NDIV_MIN = 10,
  parameter int NDIV_MAX = 125,
  parameter int ODF_STEPS = 4,
  parameter int LIMIT    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [IDF_W-1:0]  idfIn,
  input  logic [NDIV_W-1:0] ndivIn,
  input  logic [ODF_W-1:0]  odfIn,
  input  logic [UI_W-1:0]   uixIn,
  output logic              cfgValid,
  output logic              timeUp,
  output logic [IDF_W-1:0]  idfQ,
  output logic [NDIV_W-1:0] ndivQ,
  output logic [$clog2(ODF_STEPS)-1:0] odfCodeQ,
  output logic [UI_W-1:0]   uixQ
);
  localparam int CODE_W = $clog2(ODF_STEPS);
  localparam int CNT_W  = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [ODF_STEPS-1:0] odfHit;
  logic [CODE_W-1:0]    odfCode;
  logic                 idfOk, ndivOk, odfOk;
  logic [CNT_W-1:0]     cnt;

  // one comparator per legal power-of-two output divider
  for (genvar k = 0; k < ODF_STEPS; k++) begin : g_odf
    assign odfHit[k] = (odfIn == ODF_W'(1 << k));
  end

  always_comb begin
    odfCode = '0;
    for (int k = 0; k < ODF_STEPS; k++)
      if (odfHit[k]) odfCode = CODE_W'(k);
  end

  assign idfOk    = (int'(idfIn) >= IDF_MIN) && (int'(idfIn) <= IDF_MAX);
  assign ndivOk   = (int'(ndivIn) >= NDIV_MIN) && (int'(ndivIn) <= NDIV_MAX);
  assign odfOk    = |odfHit;
  assign cfgValid = idfOk && ndivOk && odfOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idfQ     <= '0;
      ndivQ    <= '0;
      odfCodeQ <= '0;
      uixQ     <= '0;
    end else if (ctl.latchCfg) begin
      idfQ     <= idfIn;
      ndivQ    <= ndivIn;
      odfCodeQ <= odfCode;
      uixQ     <= uixIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.cntClr)  cnt <= '0;
    else if (ctl.cntEn)   cnt <= cnt + 1'b1;
  end

  assign timeUp = (cnt == LAST);
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   start,
  input  logic   videoMode,
  input  logic   regReady,
  input  logic   pllLock,
  input  logic   cfgValid,
  input  logic   timeUp,
  output dpCtl_t ctl,
  output logic   bgEn,
  output logic   regEn,
  output logic   pllEn,
  output logic   wrapEn,
  output logic   done,
  output logic   paramErr,
  output logic   timeoutErr,
  output logic   failStep
);
  seqState_t state, nxt;
  logic      tryStart;

  assign tryStart = enable && start && (state == ST_IDLE || state == ST_FAIL);

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      ST_IDLE, ST_FAIL: begin
        if (!enable) nxt = ST_IDLE;
        else if (start) begin
          if (cfgValid) begin
            nxt          = ST_WREG;
            ctl.latchCfg = 1'b1;
            ctl.cntClr   = 1'b1;
          end else nxt = ST_IDLE;
        end
      end
      ST_WREG: begin
        if (!enable) nxt = ST_DOWN;
        else if (regReady) begin
          nxt        = ST_WPLL;
          ctl.cntClr = 1'b1;
        end else if (timeUp) nxt = ST_FAIL;
        else ctl.cntEn = 1'b1;
      end
      ST_WPLL: begin
        if (!enable) nxt = ST_DOWN;
        else if (pllLock) nxt = ST_UP;
        else if (timeUp) nxt = ST_FAIL;
        else ctl.cntEn = 1'b1;
      end
      ST_UP:   if (!enable) nxt = ST_DOWN;
      ST_DOWN: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      paramErr <= 1'b0;
      failStep <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_WPLL) && (nxt == ST_UP);
      if (tryStart) paramErr <= !cfgValid;
      if (nxt == ST_FAIL && state != ST_FAIL) failStep <= (state == ST_WPLL);
    end
  end

  assign regEn      = (state == ST_WREG) || (state == ST_WPLL) ||
                      (state == ST_UP)   || (state == ST_DOWN);
  assign bgEn       = regEn;
  assign pllEn      = (state == ST_WPLL) || (state == ST_UP);
  assign wrapEn     = (state == ST_UP) && videoMode;
  assign timeoutErr = (state == ST_FAIL);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 100,
  parameter int TIMEOUT_US    = 200000,
  parameter int IDF_W         = 4,
  parameter int NDIV_W        = 7,
  parameter int ODF_W         = 4,
  parameter int UI_W          = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              start,
  input  logic              videoMode,
  input  logic [IDF_W-1:0]  idfIn,
  input  logic [NDIV_W-1:0] ndivIn,
  input  logic [ODF_W-1:0]  odfIn,
  input  logic [UI_W-1:0]   uix4In,
  input  logic              regReady,
  input  logic              pllLock,
  output logic              bgEn,
  output logic              regEn,
  output logic              pllEn,
  output logic              wrapEn,
  output logic [IDF_W-1:0]  idfOut,
  output logic [NDIV_W-1:0] ndivOut,
  output logic [1:0]        odfCode,
  output logic [UI_W-1:0]   uix4Out,
  output logic              done,
  output logic              paramErr,
  output logic              timeoutErr,
  output logic              failStep
);
  localparam int LIMIT = CYCLES_PER_US * TIMEOUT_US;

  dpCtl_t ctl;
  logic   cfgValid, timeUp;

  phy_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start),
    .videoMode(videoMode), .regReady(regReady), .pllLock(pllLock),
    .cfgValid(cfgValid), .timeUp(timeUp), .ctl(ctl),
    .bgEn(bgEn), .regEn(regEn), .pllEn(pllEn), .wrapEn(wrapEn),
    .done(done), .paramErr(paramErr), .timeoutErr(timeoutErr),
    .failStep(failStep)
  );

  phy_seq_dp #(
    .IDF_W(IDF_W), .NDIV_W(NDIV_W), .ODF_W(ODF_W), .UI_W(UI_W),
    .ODF_STEPS(4), .LIMIT(LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .idfIn(idfIn), .ndivIn(ndivIn), .odfIn(odfIn), .uixIn(uix4In),
    .cfgValid(cfgValid), .timeUp(timeUp),
    .idfQ(idfOut), .ndivQ(ndivOut), .odfCodeQ(odfCode), .uixQ(uix4Out)
  );
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic videoMode,
  input logic regReady,
  input logic pllLock,
  input logic bgEn,
  input logic regEn,
  input logic pllEn,
  input logic wrapEn,
  input logic done,
  input logic paramErr,
  input logic timeoutErr
);
  assert_pll_after_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> $past(regReady) && $past(regEn));

  assert_pll_needs_reg_R1: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> regEn && bgEn);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(pllLock) && pllEn);

  assert_wrap_video_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrapEn |-> videoMode && pllEn);

  assert_fail_all_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !regEn && !bgEn && !pllEn);

  assert_shutdown_order_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(regEn) && !timeoutErr) |-> !$past(pllEn));

  assert_reject_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |-> !regEn);
endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .videoMode(videoMode),
  .regReady(regReady), .pllLock(pllLock), .bgEn(bgEn), .regEn(regEn),
  .pllEn(pllEn), .wrapEn(wrapEn), .done(done), .paramErr(paramErr),
  .timeoutErr(timeoutErr)
);

// File: tb/test_phy_pwr_seq.sv
`timescale 1ns/1ps
module test_phy_pwr_seq;
  localparam int CPU   = 2;
  localparam int TUS   = 10;
  localparam int LIMIT = CPU * TUS;

  logic clk = 0, rstN = 0;
  logic enable = 0, start = 0, videoMode = 1, regReady = 0, pllLock = 0;
  logic [3:0] idfIn = 4'd1, odfIn = 4'd1;
  logic [6:0] ndivIn = 7'd10;
  logic [5:0] uix4In = 6'd0;
  logic bgEn, regEn, pllEn, wrapEn, done, paramErr, timeoutErr, failStep;
  logic [3:0] idfOut;
  logic [6:0] ndivOut;
  logic [1:0] odfCode;
  logic [5:0] uix4Out;

  int nChk = 0, nBad = 0;

  always #2 clk = ~clk;

  phy_pwr_seq #(.CYCLES_PER_US(CPU), .TIMEOUT_US(TUS)) i_phy_pwr_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start),
    .videoMode(videoMode), .idfIn(idfIn), .ndivIn(ndivIn), .odfIn(odfIn),
    .uix4In(uix4In), .regReady(regReady), .pllLock(pllLock),
    .bgEn(bgEn), .regEn(regEn), .pllEn(pllEn), .wrapEn(wrapEn),
    .idfOut(idfOut), .ndivOut(ndivOut), .odfCode(odfCode), .uix4Out(uix4Out),
    .done(done), .paramErr(paramErr), .timeoutErr(timeoutErr),
    .failStep(failStep)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic toIdle();
    @(negedge clk) enable = 0; regReady = 0; pllLock = 0;
    @(negedge clk);
    @(negedge clk) enable = 1;
  endtask

  // bring up with regulator delay dr and lock delay dl (cycles into each wait)
  task automatic bringUp(input int dr, input int dl);
    pulseStart();
    chk("R1 regEn", regEn, 1); chk("R1 bgEn", bgEn, 1); chk("R1 pllEn", pllEn, 0);
    repeat (dr) @(negedge clk);
    chk("R2 pll early", pllEn, 0);
    regReady = 1;
    @(negedge clk);
    chk("R2 pllEn", pllEn, 1); chk("R4 no err", timeoutErr, 0);
    repeat (dl) @(negedge clk);
    chk("R3 no early done", done, 0);
    pllLock = 1;
    @(negedge clk);
    chk("R3 done", done, 1);
    @(negedge clk);
    chk("R3 done one cycle", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    chk("R1 reset regEn", regEn, 0); chk("R1 reset pllEn", pllEn, 0);
    chk("R3 reset done", done, 0); chk("R5 reset err", timeoutErr, 0);
    @(negedge clk) rstN = 1; enable = 1;

    // R1 R2 R3 R7 R8: nominal bring-up
    idfIn = 4'd3; ndivIn = 7'd100; odfIn = 4'd4; uix4In = 6'd37;
    bringUp(3, 5);
    chk("R7 idf", idfOut, 3); chk("R7 ndiv", ndivOut, 100);
    chk("R7 odf code", odfCode, 2); chk("R8 uix4", uix4Out, 37);
    // R9 video / command
    videoMode = 1; #1 chk("R9 wrap video", wrapEn, 1);
    videoMode = 0; #1 chk("R9 wrap command", wrapEn, 0);
    videoMode = 1;
    // R11 start while running ignored
    uix4In = 6'd5; pulseStart();
    chk("R11 busy start", uix4Out, 37); chk("R11 busy pll", pllEn, 1);
    // R10 shutdown order
    @(negedge clk) enable = 0;
    @(negedge clk);
    chk("R10 pll off first", pllEn, 0); chk("R10 reg held", regEn, 1);
    chk("R10 wrap off", wrapEn, 0);
    @(negedge clk);
    chk("R10 reg off", regEn, 0); chk("R10 bg off", bgEn, 0);
    regReady = 0; pllLock = 0;
    // R11 start while enable low
    pulseStart();
    chk("R11 disabled start", regEn, 0);
    @(negedge clk) enable = 1;

    // R4 boundary: ready in the last allowed cycle of each wait
    bringUp(LIMIT - 1, LIMIT - 1);
    chk("R4 last cycle ok", pllEn, 1);
    toIdle();

    // R4 R5 regulator timeout
    pulseStart();
    repeat (LIMIT - 1) @(negedge clk);
    chk("R4 still waiting", regEn, 1); chk("R4 no err yet", timeoutErr, 0);
    @(negedge clk);
    chk("R5 reg timeout", timeoutErr, 1); chk("R5 step reg", failStep, 0);
    chk("R5 reg off", regEn, 0);
    // R5 PLL timeout, restart from failed state
    pulseStart();
    chk("R11 err cleared", timeoutErr, 0);
    regReady = 1;
    @(negedge clk);
    chk("R2 pll on", pllEn, 1);
    repeat (LIMIT - 1) @(negedge clk);
    chk("R4 pll waiting", pllEn, 1);
    @(negedge clk);
    chk("R5 pll timeout", timeoutErr, 1); chk("R5 step pll", failStep, 1);
    chk("R5 all off", pllEn | regEn | bgEn, 0);
    toIdle();

    // R6 R7 sweep over divider codes
    for (int i = 0; i < 16; i++) begin
      for (int o = 0; o < 16; o++) begin
        for (int n = 0; n < 9; n++) begin
          int nv, expCode;
          bit ok;
          case (n)
            0: nv = 0;  1: nv = 9;  2: nv = 10; 3: nv = 11; 4: nv = 64;
            5: nv = 124; 6: nv = 125; 7: nv = 126; default: nv = 127;
          endcase
          ok = (i >= 1 && i <= 7) && (nv >= 10 && nv <= 125) &&
               (o == 1 || o == 2 || o == 4 || o == 8);
          expCode = (o == 8) ? 3 : (o == 4) ? 2 : (o == 2) ? 1 : 0;
          idfIn = 4'(i); odfIn = 4'(o); ndivIn = 7'(nv);
          uix4In = 6'((i * 7 + o * 3 + nv) % 64);
          pulseStart();
          chk("R6 paramErr", paramErr, !ok);
          chk("R6 regEn", regEn, ok);
          if (ok) begin
            chk("R7 idf", idfOut, i); chk("R7 ndiv", ndivOut, nv);
            chk("R7 odf code", odfCode, expCode);
            chk("R8 uix4", uix4Out, (i * 7 + o * 3 + nv) % 64);
            toIdle();
          end
        end
      end
    end
    summary();
  end
endmodule